// File: doc/BRIEF.md
# Register Modification Recovery Log

This block keeps the information that a fault handler needs to undo a partly executed instruction and run it again. It tracks which general registers the current instruction has stepped by autoincrement or autodecrement, and by what signed amount. It also holds the address of the instruction in progress. Both are presented as read-only 16-bit words. The log is a two-entry byte shifter. Every logged register change pushes one byte into the low half of the word, and the older byte moves into the high half.

The execution unit drives the inputs. It raises `insn_start` with the fetched PC when an instruction begins. It reports operand address updates on a source port and a destination port, each with an addressing mode, a register number and a shared byte flag. It raises `sq_valid` with a sequence code for the move-to/from-previous-space and trap sequences. The abort status flags of the memory manager drive `abort_flags`. While any of these flags is set, the log and the vector load are frozen, so the state captured at the abort survives until software clears the flags. Within one cycle the work is done in this order: the clear from `insn_start`, then the source entry, then the destination entry, then the sequence entries.

Top module: `regmod_log`

## Requirements
- R1: After reset, `log_out` and `addr_out` are both 0.
- R2: On `insn_start`, `addr_out` takes `insn_pc` on the next clock. This happens even while frozen, unless a trap sequence loads a vector in the same cycle.
- R3: On `insn_start` with `abort_flags` all zero, the log is cleared before any entry of that cycle is added. While frozen, `insn_start` leaves the log unchanged.
- R4: Each entry shifts `log_out` left by 8 bits and writes the new byte into bits 7:0. In that byte, bits 2:0 hold the register number and bits 7:3 hold the change as 5-bit two's complement (+1 = 00001, +2 = 00010, -1 = 11111, -2 = 11110). The oldest byte is lost.
- R5: Operand updates with addressing mode 0 or 1 add no entry and leave the log unchanged.
- R6: Modes 4 and 5 log a negative change. Modes 2, 3, 6 and 7 log a positive change.
- R7: The magnitude is 2 for a word operation (`op_byte` = 0), for register 6 or 7, or for mode 6 or 7. Otherwise it is 1.
- R8: When source and destination updates arrive in the same cycle, the source entry goes in first and ends in bits 15:8. The destination entry ends in bits 7:0.
- R9: Sequence code 0 (from previous space) logs -2 on register 6 (byte 0xF6). Code 1 (to previous space) logs +2 on register 6 (byte 0x16).
- R10: Sequence code 2 loads `addr_out` with 030 octal and code 3 loads it with 034 octal. Both codes log two -2 entries on register 6, which gives a log of 0xF6F6 when the log starts from 0.
- R11: While `abort_flags` is nonzero, `log_out` does not change and no vector is loaded into `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start | input | 1 | Instruction fetch strobe |
| insn_pc | input | 16 | PC of the fetched instruction |
| src_valid | input | 1 | Source operand register update |
| src_mode | input | 3 | Source addressing mode |
| src_reg | input | 3 | Source register number |
| dst_valid | input | 1 | Destination operand register update |
| dst_mode | input | 3 | Destination addressing mode |
| dst_reg | input | 3 | Destination register number |
| op_byte | input | 1 | Byte operation (1) or word operation (0) |
| sq_valid | input | 1 | Explicit sequence log request |
| sq_op | input | 2 | Sequence code: 0 from-prev, 1 to-prev, 2 emulator trap, 3 trap |
| abort_flags | input | 3 | Abort error flags; nonzero freezes the log |
| log_out | output | 16 | Two-entry register modification log |
| addr_out | output | 16 | Instruction address / trap vector |

## Verification
The hardest state to reach is a frozen log that already holds two meaningful entries, such as those left by a trap sequence. The test must then show that a new fetch, a fresh operand update and another trap all leave the log alone, while the fetch still moves the address word. The bench first builds a log of 0xF6F6 with an emulator-trap sequence. It then raises an abort flag and applies each of these events in turn. Finally it drops the flag and confirms that the next fetch clears the log.

// File: rtl/regmod_pkg.sv
package regmod_pkg;

    localparam int LOG_W       = 16;
    localparam int REG_W       = 3;
    localparam int DELTA_W     = 5;
    localparam int MODE_W      = 3;
    localparam int ENTRY_W     = REG_W + DELTA_W;
    localparam int NUM_ENTRIES = LOG_W / ENTRY_W;

    typedef struct packed {
        logic [DELTA_W-1:0] delta;
        logic [REG_W-1:0]   regno;
    } entry_t;

    typedef enum logic [1:0] {
        SQ_FROM_PREV = 2'd0,
        SQ_TO_PREV   = 2'd1,
        SQ_EMU_TRAP  = 2'd2,
        SQ_SW_TRAP   = 2'd3
    } seq_op_e;

    function automatic logic [DELTA_W-1:0] signed_step(input logic neg, input logic wide);
        logic [DELTA_W-1:0] mag;
        mag = wide ? DELTA_W'(2) : DELTA_W'(1);
        return neg ? (~mag + DELTA_W'(1)) : mag;
    endfunction

endpackage

// File: rtl/regmod_step_calc.sv
module regmod_step_calc
    import regmod_pkg::*;
#(
    parameter int SP_REG = 6
) (
    input  logic              valid,
    input  logic [MODE_W-1:0] mode,
    input  logic [REG_W-1:0]  regno,
    input  logic              is_byte,
    output logic              ent_vld,
    output entry_t            ent
);
    localparam logic [MODE_W-1:0] FIRST_LOGGED = MODE_W'(2);
    localparam logic [MODE_W-1:0] DEC_A        = MODE_W'(4);
    localparam logic [MODE_W-1:0] DEC_B        = MODE_W'(5);
    localparam logic [MODE_W-1:0] INDEX_FIRST  = MODE_W'(6);

    logic neg;
    logic wide;

    always_comb begin
        neg       = (mode == DEC_A) || (mode == DEC_B);
        wide      = !is_byte || (regno >= REG_W'(SP_REG)) || (mode >= INDEX_FIRST);
        ent_vld   = valid && (mode >= FIRST_LOGGED);
        ent.regno = regno;
        ent.delta = signed_step(neg, wide);
    end
endmodule

// File: rtl/regmod_seq_expand.sv
module regmod_seq_expand
    import regmod_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SP_REG   = 6,
    parameter int EMT_VEC  = 'o30,
    parameter int TRAP_VEC = 'o34
) (
    input  logic              valid,
    input  logic [1:0]        op,
    output logic [1:0]        ent_vld,
    output entry_t            ent,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec
);
    seq_op_e op_e;

    always_comb begin
        op_e      = seq_op_e'(op);
        ent_vld   = 2'b00;
        vec_load  = 1'b0;
        vec       = ADDR_W'(EMT_VEC);
        ent.regno = REG_W'(SP_REG);
        ent.delta = signed_step(1'b1, 1'b1);
        if (valid) begin
            unique case (op_e)
                SQ_FROM_PREV: ent_vld = 2'b01;
                SQ_TO_PREV: begin
                    ent_vld   = 2'b01;
                    ent.delta = signed_step(1'b0, 1'b1);
                end
                SQ_EMU_TRAP: begin
                    ent_vld  = 2'b11;
                    vec_load = 1'b1;
                end
                SQ_SW_TRAP: begin
                    ent_vld  = 2'b11;
                    vec_load = 1'b1;
                    vec      = ADDR_W'(TRAP_VEC);
                end
                default: ent_vld = 2'b00;
            endcase
        end
    end
endmodule

// File: rtl/regmod_log_core.sv
module regmod_log_core
    import regmod_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    clr,
    input  logic [NSLOT-1:0]        slot_vld,
    input  entry_t [NSLOT-1:0]      slot_ent,
    output logic [LOG_W-1:0]        log_q
);
    localparam int KEEP_W = LOG_W - ENTRY_W;

    typedef struct packed {
        logic [LOG_W-1:0] log;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (clr) begin
                st_d.log = '0;
            end
            for (int i = 0; i < NSLOT; i++) begin
                if (slot_vld[i]) begin
                    st_d.log = {st_d.log[KEEP_W-1:0], slot_ent[i]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign log_q = st_q.log;
endmodule

// File: rtl/regmod_addr_reg.sv
module regmod_addr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pc,
    input  logic [ADDR_W-1:0] pc,
    input  logic              load_vec,
    input  logic [ADDR_W-1:0] vec,
    output logic [ADDR_W-1:0] addr_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_pc) begin
            st_d.addr = pc;
        end
        if (load_vec) begin
            st_d.addr = vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q = st_q.addr;
endmodule

// File: rtl/regmod_log.sv
module regmod_log
    import regmod_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int FLAG_W   = 3,
    parameter int SP_REG   = 6,
    parameter int EMT_VEC  = 'o30,
    parameter int TRAP_VEC = 'o34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_start,
    input  logic [ADDR_W-1:0] insn_pc,
    input  logic              src_valid,
    input  logic [MODE_W-1:0] src_mode,
    input  logic [REG_W-1:0]  src_reg,
    input  logic              dst_valid,
    input  logic [MODE_W-1:0] dst_mode,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic              op_byte,
    input  logic              sq_valid,
    input  logic [1:0]        sq_op,
    input  logic [FLAG_W-1:0] abort_flags,
    output logic [LOG_W-1:0]  log_out,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int NOPER = 2;
    localparam int NSEQ  = 2;
    localparam int NSLOT = NOPER + NSEQ;

    logic                     frozen;
    logic [NOPER-1:0]         opr_valid;
    logic [NOPER-1:0][MODE_W-1:0] opr_mode;
    logic [NOPER-1:0][REG_W-1:0]  opr_reg;
    logic [NOPER-1:0]         opr_ent_vld;
    entry_t [NOPER-1:0]       opr_ent;
    logic [NSEQ-1:0]          seq_vld;
    entry_t                   seq_ent;
    logic                     seq_vec_load;
    logic [ADDR_W-1:0]        seq_vec;
    logic [NSLOT-1:0]         slot_vld;
    entry_t [NSLOT-1:0]       slot_ent;

    assign frozen       = |abort_flags;
    assign opr_valid    = {dst_valid, src_valid};
    assign opr_mode     = {dst_mode, src_mode};
    assign opr_reg      = {dst_reg, src_reg};

    for (genvar g = 0; g < NOPER; g++) begin : g_opr
        regmod_step_calc #(
            .SP_REG (SP_REG)
        ) u_step (
            .valid   (opr_valid[g]),
            .mode    (opr_mode[g]),
            .regno   (opr_reg[g]),
            .is_byte (op_byte),
            .ent_vld (opr_ent_vld[g]),
            .ent     (opr_ent[g])
        );
        assign slot_vld[g] = opr_ent_vld[g];
        assign slot_ent[g] = opr_ent[g];
    end

    regmod_seq_expand #(
        .ADDR_W   (ADDR_W),
        .SP_REG   (SP_REG),
        .EMT_VEC  (EMT_VEC),
        .TRAP_VEC (TRAP_VEC)
    ) u_seq (
        .valid    (sq_valid),
        .op       (sq_op),
        .ent_vld  (seq_vld),
        .ent      (seq_ent),
        .vec_load (seq_vec_load),
        .vec      (seq_vec)
    );

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        assign slot_vld[NOPER+s] = seq_vld[s];
        assign slot_ent[NOPER+s] = seq_ent;
    end

    regmod_log_core #(
        .NSLOT (NSLOT)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (frozen),
        .clr      (insn_start),
        .slot_vld (slot_vld),
        .slot_ent (slot_ent),
        .log_q    (log_out)
    );

    regmod_addr_reg #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_pc  (insn_start),
        .pc       (insn_pc),
        .load_vec (seq_vec_load && !frozen),
        .vec      (seq_vec),
        .addr_q   (addr_out)
    );
endmodule

// File: rtl/regmod_log_chk.sv
module regmod_log_chk
    import regmod_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int FLAG_W   = 3,
    parameter int EMT_VEC  = 'o30,
    parameter int TRAP_VEC = 'o34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_start,
    input logic [ADDR_W-1:0] insn_pc,
    input logic              src_valid,
    input logic [MODE_W-1:0] src_mode,
    input logic [REG_W-1:0]  src_reg,
    input logic              dst_valid,
    input logic              sq_valid,
    input logic [1:0]        sq_op,
    input logic [FLAG_W-1:0] abort_flags,
    input logic [LOG_W-1:0]  log_out,
    input logic [ADDR_W-1:0] addr_out
);
    logic open;
    logic quiet_src;
    assign open      = (abort_flags == '0);
    assign quiet_src = !dst_valid && !sq_valid && !insn_start;

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        insn_start && !(sq_valid && sq_op[1] && open) |=> addr_out == $past(insn_pc)); // R2

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        insn_start && open && !src_valid && !dst_valid && !sq_valid |=> log_out == '0); // R3

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid && src_mode >= 3'd2 && quiet_src && open
        |=> log_out[LOG_W-1:ENTRY_W] == $past(log_out[ENTRY_W-1:0])
            && log_out[REG_W-1:0] == $past(src_reg)); // R4

    AST_NO_ENTRY_LOW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid && src_mode <= 3'd1 && quiet_src |=> $stable(log_out)); // R5

    AST_FROM_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid && sq_op == 2'd0 && open && !src_valid && !dst_valid
        |=> log_out[ENTRY_W-1:0] == 8'hF6); // R9

    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid && sq_op[1] && open
        |=> addr_out == (sq_op[0] ? ADDR_W'(TRAP_VEC) : ADDR_W'(EMT_VEC))); // R10

    AST_FROZEN_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(log_out)); // R11

    AST_FROZEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !open && !insn_start |=> $stable(addr_out)); // R11
endmodule

bind regmod_log regmod_log_chk #(
    .ADDR_W   (ADDR_W),
    .FLAG_W   (FLAG_W),
    .EMT_VEC  (EMT_VEC),
    .TRAP_VEC (TRAP_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_start  (insn_start),
    .insn_pc     (insn_pc),
    .src_valid   (src_valid),
    .src_mode    (src_mode),
    .src_reg     (src_reg),
    .dst_valid   (dst_valid),
    .sq_valid    (sq_valid),
    .sq_op       (sq_op),
    .abort_flags (abort_flags),
    .log_out     (log_out),
    .addr_out    (addr_out)
);

// File: tb/regmod_log_tb.sv
module regmod_log_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_start = 1'b0;
    logic [15:0] insn_pc = '0;
    logic        src_valid = 1'b0;
    logic [2:0]  src_mode = '0;
    logic [2:0]  src_reg = '0;
    logic        dst_valid = 1'b0;
    logic [2:0]  dst_mode = '0;
    logic [2:0]  dst_reg = '0;
    logic        op_byte = 1'b0;
    logic        sq_valid = 1'b0;
    logic [1:0]  sq_op = '0;
    logic [2:0]  abort_flags = '0;
    logic [15:0] log_out;
    logic [15:0] addr_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    regmod_log u_dut (
        .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_pc(insn_pc),
        .src_valid(src_valid), .src_mode(src_mode), .src_reg(src_reg),
        .dst_valid(dst_valid), .dst_mode(dst_mode), .dst_reg(dst_reg),
        .op_byte(op_byte), .sq_valid(sq_valid), .sq_op(sq_op),
        .abort_flags(abort_flags), .log_out(log_out), .addr_out(addr_out)
    );

    // {logs, mode, reg, byte, expected low byte}
    localparam logic [15:0] VECS [14] = '{
        {1'b1, 3'd2, 3'd0, 1'b0, 8'h10},
        {1'b1, 3'd2, 3'd0, 1'b1, 8'h08},
        {1'b1, 3'd4, 3'd3, 1'b1, 8'hFB},
        {1'b1, 3'd4, 3'd3, 1'b0, 8'hF3},
        {1'b1, 3'd5, 3'd1, 1'b1, 8'hF9},
        {1'b1, 3'd3, 3'd2, 1'b1, 8'h0A},
        {1'b1, 3'd2, 3'd6, 1'b1, 8'h16},
        {1'b1, 3'd2, 3'd7, 1'b1, 8'h17},
        {1'b1, 3'd4, 3'd7, 1'b1, 8'hF7},
        {1'b1, 3'd6, 3'd1, 1'b1, 8'h11},
        {1'b1, 3'd7, 3'd5, 1'b1, 8'h15},
        {1'b1, 3'd5, 3'd6, 1'b0, 8'hF6},
        {1'b0, 3'd0, 3'd2, 1'b0, 8'h00},
        {1'b0, 3'd1, 3'd4, 1'b1, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        insn_start = 1'b0;
        src_valid  = 1'b0;
        dst_valid  = 1'b0;
        sq_valid   = 1'b0;
    endtask

    task automatic start(input logic [15:0] pc);
        insn_start = 1'b1;
        insn_pc    = pc;
        tick();
    endtask

    task automatic src_ev(input logic [2:0] m, input logic [2:0] r, input logic b);
        src_valid = 1'b1;
        src_mode  = m;
        src_reg   = r;
        op_byte   = b;
        tick();
    endtask

    task automatic seq_ev(input logic [1:0] op);
        sq_valid = 1'b1;
        sq_op    = op;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 log reset", log_out, 16'h0000);
        chk("R1 addr reset", addr_out, 16'h0000);
        rst_n = 1'b1;
        tick();

        // table walk: preload +2 on R0, then one operand update
        foreach (VECS[i]) begin
            start(16'h0100 + 16'(i * 2));
            src_ev(3'd2, 3'd0, 1'b0);
            src_ev(VECS[i][14:12], VECS[i][11:9], VECS[i][8]);
            if (VECS[i][15])
                chk("R6 R7 R4 table entry", log_out, {8'h10, VECS[i][7:0]});
            else
                chk("R5 mode 0/1 no entry", log_out, 16'h0010);
        end

        start(16'h0200);
        chk("R2 pc load", addr_out, 16'h0200);
        chk("R3 clear on start", log_out, 16'h0000);

        src_valid = 1'b1; src_mode = 3'd2; src_reg = 3'd1; op_byte = 1'b1;
        dst_valid = 1'b1; dst_mode = 3'd4; dst_reg = 3'd2;
        op_byte = 1'b1;
        src_reg = 3'd1; src_mode = 3'd2;
        // source byte op on R1 mode 2 -> +1 (0x09); dest mode 4 R2 byte -> -1 (0xFA)
        tick();
        chk("R8 source then destination", log_out, 16'h09FA);

        src_ev(3'd3, 3'd3, 1'b0);
        chk("R4 oldest entry dropped", log_out, 16'hFA13);

        start(16'h0202);
        chk("R3 clear after entries", log_out, 16'h0000);

        seq_ev(2'd0);
        chk("R9 from previous space", log_out, 16'h00F6);
        seq_ev(2'd1);
        chk("R9 to previous space", log_out, 16'hF616);

        start(16'h0300);
        seq_ev(2'd2);
        chk("R10 emulator trap log", log_out, 16'hF6F6);
        chk("R10 emulator trap vector", addr_out, 16'o30);
        start(16'h0304);
        seq_ev(2'd3);
        chk("R10 trap log", log_out, 16'hF6F6);
        chk("R10 trap vector", addr_out, 16'o34);

        abort_flags = 3'b100;
        start(16'h0400);
        chk("R11 frozen start keeps log", log_out, 16'hF6F6);
        chk("R2 frozen start loads pc", addr_out, 16'h0400);
        src_ev(3'd2, 3'd0, 1'b0);
        chk("R11 frozen operand ignored", log_out, 16'hF6F6);
        seq_ev(2'd2);
        chk("R11 frozen trap log", log_out, 16'hF6F6);
        chk("R11 frozen trap no vector", addr_out, 16'h0400);
        abort_flags = 3'b000;
        start(16'h0402);
        chk("R3 clear after unfreeze", log_out, 16'h0000);
        chk("R2 pc after unfreeze", addr_out, 16'h0402);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule